// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Detection

This block is a register-mapped general-purpose I/O controller that handles a configurable number of pins, up to 32. Software sets the direction and output level of each pin through a word-wide register bus. It reads back pin levels through the same bus. It also chooses how each pin raises an interrupt: on a high level, a low level, a rising edge, a falling edge, or both edges. Each pin input goes through a two-stage synchroniser before any detection. Detected conditions are held in a status word. A per-pin enable masks that word into a pending word, and the OR of all pending bits drives a single interrupt line. Software acknowledges an event by writing ones to a clear register.

A build parameter sets the hardware version, and the version register returns it. The both-edges select register exists only when the version is 3 or higher. Below that, it reads zero and ignores writes. Register and pin bits at or above the pin count do not exist.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (pinOe all 0), the output values are 0, the interrupt enable word reads 0 and irqOut is 0.
- R2: A direction bit of 1 makes its pin an input (pinOe bit 0). A direction bit of 0 makes its pin an output: pinOe bit is 1 and pinOut follows the value register bit from the clock edge that samples the write.
- R3: Reading the value register returns the synchronised pin level for input pins, visible two clock edges after the pin changes. For output pins it returns the value register bit.
- R4: With its edge-select bit at 0, a pin is level-detected. Polarity 1 sets its status bit while the pin is high. Polarity 0 sets it while the pin is low.
- R5: With its edge-select bit at 1 and both-edges bit at 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge into status. The bit stays set until cleared. A status bit shows an event three clock edges after the pin changes.
- R6: With both its edge-select bit and its both-edges bit at 1, either transition latches the status bit, whatever the polarity.
- R7: The version register returns the HW_VERSION parameter. When HW_VERSION is below 3, the both-edges register reads 0, ignores writes and has no effect on detection.
- R8: The pending register reads status AND enable, and irqOut is 1 exactly when any pending bit is 1.
- R9: Writing the clear register clears each status bit whose data bit is 1, and leaves bits written 0 unchanged. A level condition that is still active keeps its status bit set across a clear.
- R10: If a clear of a status bit and a new edge on that pin fall in the same cycle, the bit stays set.
- R11: Register bits at or above NPINS read 0, and writes to them have no effect.
- R12: Registers sit at fixed byte offsets: 0x08 enable, 0x00 value, 0x18 edge select, 0x04 direction, 0x24 both edges, 0x10 pending, 0x1C polarity, 0x0C status, 0x20 version, 0x14 clear. Status, pending and version are read-only. The clear register reads 0. Accesses with busAddr[1:0] not 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access request for the current cycle |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the addressed register |
| pinIn | input | NPINS | Pin levels from the pads, asynchronous |
| pinOut | output | NPINS | Output levels to the pads |
| pinOe | output | NPINS | Output enable, 1 drives the pad |
| irqOut | output | 1 | Combined interrupt |

## Verification
A register write takes effect at the clock edge that samples it. A read returns combinationally in the same cycle. pinOut and pinOe therefore change at that edge, and an input level shows in the value register two edges after the pin moves. The bench reads one edge after and two edges after to confirm the exact stage. Status and irqOut follow a pin change at the third edge, so every detection check waits three edges after driving the pin. The same-cycle clear case places the clear write at exactly that third edge. Stimulus is driven one time unit after a rising edge, and results are sampled there too, well away from the next active edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_IDX_W = 4;

  localparam logic [REG_IDX_W-1:0] IDX_VAL  = 4'd0;
  localparam logic [REG_IDX_W-1:0] IDX_DIR  = 4'd1;
  localparam logic [REG_IDX_W-1:0] IDX_EN   = 4'd2;
  localparam logic [REG_IDX_W-1:0] IDX_STAT = 4'd3;
  localparam logic [REG_IDX_W-1:0] IDX_PEND = 4'd4;
  localparam logic [REG_IDX_W-1:0] IDX_CLR  = 4'd5;
  localparam logic [REG_IDX_W-1:0] IDX_EDGE = 4'd6;
  localparam logic [REG_IDX_W-1:0] IDX_POL  = 4'd7;
  localparam logic [REG_IDX_W-1:0] IDX_VER  = 4'd8;
  localparam logic [REG_IDX_W-1:0] IDX_BOTH = 4'd9;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic wrVal;
    logic wrDir;
    logic wrEn;
    logic wrClr;
    logic wrEdge;
    logic wrPol;
    logic wrBoth;
    logic rdValid;
    logic [REG_IDX_W-1:0] rdIdx;
  } ctrlStrobeS;
endpackage

// File: rtl/gpio_irq_ctrl_decode.sv
module gpio_irq_ctrl_decode
  import gpio_irq_pkg::*;
(
  input  logic       busSel,
  input  logic       busWr,
  input  logic [5:0] busAddr,
  output ctrlStrobeS strb
);
  logic aligned;
  logic [REG_IDX_W-1:0] idx;
  logic doWr;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign idx     = busAddr[5:2];
  assign doWr    = busSel && busWr && aligned;

  always_comb begin
    strb         = '0;
    strb.rdIdx   = idx;
    strb.rdValid = busSel && !busWr && aligned;
    if (doWr) begin
      unique case (idx)
        IDX_VAL:  strb.wrVal  = 1'b1;
        IDX_DIR:  strb.wrDir  = 1'b1;
        IDX_EN:   strb.wrEn   = 1'b1;
        IDX_CLR:  strb.wrClr  = 1'b1;
        IDX_EDGE: strb.wrEdge = 1'b1;
        IDX_POL:  strb.wrPol  = 1'b1;
        IDX_BOTH: strb.wrBoth = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_sync.sv
module gpio_irq_ctrl_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= dIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign qOut = stage[STAGES-1];
endmodule

// File: rtl/gpio_irq_ctrl_datapath.sv
module gpio_irq_ctrl_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int HW_VERSION = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeS       strb,
  input  logic [31:0]      wdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [31:0]      rdata,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irqOut,
  output logic [31:0]      statusOut
);
  localparam logic [31:0] PIN_MASK =
    (NPINS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NPINS) - 32'd1);
  localparam bit HAS_BOTH = (HW_VERSION >= 3);

  logic [31:0] valQ, dirQ, enQ, edgeQ, polQ, bothQ, statusQ;
  logic [31:0] syncQ, prevQ, riseV, fallV, hitV, clrMask, pendV, levelV;
  logic [31:0] wMasked;

  assign wMasked = wdata & PIN_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valQ  <= '0;
      dirQ  <= PIN_MASK;
      enQ   <= '0;
      edgeQ <= '0;
      polQ  <= '0;
    end else begin
      if (strb.wrVal)  valQ  <= wMasked;
      if (strb.wrDir)  dirQ  <= wMasked;
      if (strb.wrEn)   enQ   <= wMasked;
      if (strb.wrEdge) edgeQ <= wMasked;
      if (strb.wrPol)  polQ  <= wMasked;
    end
  end

  generate
    if (HAS_BOTH) begin : gBothReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            bothQ <= '0;
        else if (strb.wrBoth) bothQ <= wMasked;
      end
    end else begin : gBothNone
      assign bothQ = '0;
    end
  endgenerate

  gpio_irq_ctrl_sync #(.WIDTH(32), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (32'(pinIn)),
    .qOut (syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ;
  end

  assign riseV = syncQ & ~prevQ;
  assign fallV = ~syncQ & prevQ;

  generate
    for (genvar i = 0; i < 32; i++) begin : gBit
      if (i < NPINS) begin : gLive
        assign hitV[i] = edgeQ[i]
          ? (bothQ[i] ? (riseV[i] | fallV[i]) : (polQ[i] ? riseV[i] : fallV[i]))
          : (polQ[i] ? syncQ[i] : ~syncQ[i]);
      end else begin : gDead
        assign hitV[i] = 1'b0;
      end
    end
  endgenerate

  assign clrMask = strb.wrClr ? wMasked : 32'd0;

  // new hits take priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= ((statusQ & ~clrMask) | hitV) & PIN_MASK;
  end

  assign pendV  = statusQ & enQ;
  assign irqOut = |pendV;
  assign levelV = ((syncQ & dirQ) | (valQ & ~dirQ)) & PIN_MASK;

  always_comb begin
    rdata = '0;
    if (strb.rdValid) begin
      unique case (strb.rdIdx)
        IDX_VAL:  rdata = levelV;
        IDX_DIR:  rdata = dirQ;
        IDX_EN:   rdata = enQ;
        IDX_STAT: rdata = statusQ;
        IDX_PEND: rdata = pendV;
        IDX_EDGE: rdata = edgeQ;
        IDX_POL:  rdata = polQ;
        IDX_VER:  rdata = 32'(HW_VERSION);
        IDX_BOTH: rdata = bothQ;
        default:  rdata = '0;
      endcase
    end
  end

  assign pinOut    = valQ[NPINS-1:0];
  assign pinOe     = ~dirQ[NPINS-1:0];
  assign statusOut = statusQ;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int HW_VERSION = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [5:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irqOut
);
  ctrlStrobeS  strb;
  logic [31:0] statusW;

  gpio_irq_ctrl_decode uDecode (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gpio_irq_ctrl_datapath #(.NPINS(NPINS), .HW_VERSION(HW_VERSION)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (busWdata),
    .pinIn     (pinIn),
    .rdata     (busRdata),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .irqOut    (irqOut),
    .statusOut (statusW)
  );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int HW_VERSION = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic [5:0]       busAddr,
  input logic [31:0]      busWdata,
  input logic [31:0]      busRdata,
  input logic [NPINS-1:0] pinOut,
  input logic [NPINS-1:0] pinOe,
  input logic             irqOut,
  input logic [31:0]      statusW
);
  logic wrDir, wrVal, wrEn, wrClr, rdVer, rdPend;
  assign wrDir  = busSel && busWr && busAddr == {IDX_DIR, 2'b00};
  assign wrVal  = busSel && busWr && busAddr == {IDX_VAL, 2'b00};
  assign wrEn   = busSel && busWr && busAddr == {IDX_EN, 2'b00};
  assign wrClr  = busSel && busWr && busAddr == {IDX_CLR, 2'b00};
  assign rdVer  = busSel && !busWr && busAddr == {IDX_VER, 2'b00};
  assign rdPend = busSel && !busWr && busAddr == {IDX_PEND, 2'b00};

  assert_dir_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrDir |=> pinOe == ~$past(busWdata[NPINS-1:0]));

  assert_val_out_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrVal |=> pinOut == $past(busWdata[NPINS-1:0]));

  assert_fall_needs_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusW) & ~statusW) != 32'd0) |-> $past(wrClr));

  assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> (statusW != $past(statusW)) || $past(wrEn));

  assert_enable_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busWdata == 32'd0) |=> !irqOut);

  assert_version_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdVer |-> busRdata == 32'(HW_VERSION));

  assert_pend_in_status_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdPend |-> (busRdata & ~statusW) == 32'd0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .HW_VERSION(HW_VERSION)) uChk (.*);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  localparam int NP = 20;
  localparam logic [31:0] MASK = 32'h000F_FFFF;
  localparam logic [5:0] A_VAL = 6'h00, A_DIR = 6'h04, A_EN = 6'h08, A_STAT = 6'h0C,
                         A_PEND = 6'h10, A_CLR = 6'h14, A_EDGE = 6'h18, A_POL = 6'h1C,
                         A_VER = 6'h20, A_BOTH = 6'h24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rd0, rd1;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] out0, oe0, out1, oe1;
  logic irq0, irq1;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .HW_VERSION(3)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rd0), .pinIn(pinIn), .pinOut(out0),
    .pinOe(oe0), .irqOut(irq0));

  gpio_irq_ctrl #(.NPINS(NP), .HW_VERSION(2)) u1 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rd1), .pinIn(pinIn), .pinOut(out1),
    .pinOe(oe1), .irqOut(irq1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d0, output logic [31:0] d1);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d0 = rd0; d1 = rd1;
    busSel = 1'b0;
    #1;
  endtask

  // expected status after pin k moves from a to b under a given mode
  function automatic bit expHit(input int mode, input bit a, input bit b);
    case (mode)
      0: return b;
      1: return !b;
      2: return !a && b;
      3: return a && !b;
      default: return a != b;
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r0, r1, s0;
    int unused;
    unused = $urandom(32'd20240);
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    #1;

    // R1 reset state
    check("R1 oe", 32'(oe0), 32'd0);
    check("R1 out", 32'(out0), 32'd0);
    check("R1 irq", 32'(irq0), 32'd0);
    rd(A_EN, r0, r1);  check("R1 enable", r0, 32'd0);
    rd(A_DIR, r0, r1); check("R1 dir R11 mask", r0, MASK);

    // R3 value read timing
    pinIn = 20'hA5A5A;
    waitCyc(1);
    rd(A_VAL, r0, r1); check("R3 one edge old", r0, 32'd0);
    waitCyc(1);
    rd(A_VAL, r0, r1); check("R3 two edges new", r0, 32'h000A5A5A);

    // R2 direction and output
    wr(A_DIR, 32'hFFFF_FFF0);
    wr(A_VAL, 32'h5);
    check("R2 oe", 32'(oe0), 32'hF);
    check("R2 out", 32'(out0), 32'h5);
    rd(A_VAL, r0, r1); check("R3 mixed read", r0, (32'h000A5A5A & 32'hFFFF0) | 32'h5);
    wr(A_DIR, 32'hFFFF_FFFF);
    wr(A_VAL, 32'h0);
    check("R2 back to input", 32'(oe0), 32'd0);

    // R11 unused bits
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, r0, r1); check("R11 enable mask", r0, MASK);
    wr(A_EN, 32'h0);

    // R12 read-only / offsets
    pinIn = '0;
    waitCyc(4);
    rd(A_STAT, s0, r1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, r0, r1); check("R12 status read-only", r0, s0);
    wr(A_VER, 32'h0);
    rd(A_VER, r0, r1); check("R12 R7 version u0", r0, 32'd3);
    check("R7 version u1", r1, 32'd2);
    rd(A_CLR, r0, r1); check("R12 clear reads 0", r0, 32'd0);
    wr(A_POL, 32'h1);
    rd(A_POL, r0, r1); check("R12 polarity offset", r0, 32'h1);
    wr(6'h1D, 32'h0);
    rd(A_POL, r0, r1); check("R12 unaligned ignored", r0, 32'h1);

    // R4 level high on pin 2
    wr(A_EDGE, 32'h0); wr(A_POL, 32'h4); wr(A_CLR, 32'hFFFF_FFFF);
    pinIn[2] = 1'b1;
    waitCyc(3);
    rd(A_STAT, r0, r1); check("R4 level high", r0 & 32'h4, 32'h4);
    wr(A_CLR, 32'h4);
    rd(A_STAT, r0, r1); check("R9 level reasserts", r0 & 32'h4, 32'h4);
    pinIn[2] = 1'b0;
    waitCyc(3);
    wr(A_CLR, 32'h4);
    rd(A_STAT, r0, r1); check("R9 cleared inactive", r0 & 32'h4, 32'h0);
    wr(A_POL, 32'h0);
    wr(A_CLR, 32'h4);
    rd(A_STAT, r0, r1); check("R4 level low", r0 & 32'h4, 32'h4);

    // R5 rising edge
    wr(A_EDGE, 32'h4); wr(A_POL, 32'h4);
    waitCyc(3);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_STAT, r0, r1); check("R5 idle", r0 & 32'h4, 32'h0);
    pinIn[2] = 1'b1;
    waitCyc(2);
    rd(A_STAT, r0, r1); check("R5 not yet at two edges", r0 & 32'h4, 32'h0);
    waitCyc(1);
    rd(A_STAT, r0, r1); check("R5 rise latched", r0 & 32'h4, 32'h4);
    pinIn[2] = 1'b0;
    waitCyc(3);
    wr(A_CLR, 32'h0);
    rd(A_STAT, r0, r1); check("R9 zero bits no effect", r0 & 32'h4, 32'h4);
    wr(A_CLR, 32'h4);
    rd(A_STAT, r0, r1); check("R5 cleared", r0 & 32'h4, 32'h0);

    // R8 masking
    pinIn[2] = 1'b1;
    waitCyc(3);
    check("R8 masked irq", 32'(irq0), 32'd0);
    rd(A_PEND, r0, r1); check("R8 masked pending", r0, 32'd0);
    wr(A_EN, 32'h4);
    check("R8 irq enabled", 32'(irq0), 32'd1);
    rd(A_PEND, r0, r1); check("R8 pending", r0, 32'h4);
    wr(A_CLR, 32'h4);
    check("R8 irq after clear", 32'(irq0), 32'd0);

    // R10 clear and edge in the same cycle
    pinIn[2] = 1'b0;
    waitCyc(3);
    wr(A_CLR, 32'hFFFF_FFFF);
    pinIn[2] = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    wr(A_CLR, 32'h4);
    rd(A_STAT, r0, r1); check("R10 edge wins", r0 & 32'h4, 32'h4);
    wr(A_CLR, 32'h4);
    rd(A_STAT, r0, r1); check("R10 later clear", r0 & 32'h4, 32'h0);
    wr(A_EN, 32'h0);

    // R6 both edges, and R7 on the older version
    pinIn[2] = 1'b0;
    wr(A_POL, 32'h0); wr(A_BOTH, 32'h4);
    waitCyc(3);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_BOTH, r0, r1);
    check("R6 both reg", r0, 32'h4);
    check("R7 both absent", r1, 32'h0);
    pinIn[2] = 1'b1;
    waitCyc(3);
    rd(A_STAT, r0, r1);
    check("R6 rise with pol0", r0 & 32'h4, 32'h4);
    check("R7 no both-edge u1", r1 & 32'h4, 32'h0);
    wr(A_CLR, 32'h4);
    pinIn[2] = 1'b0;
    waitCyc(3);
    rd(A_STAT, r0, r1); check("R6 fall", r0 & 32'h4, 32'h4);

    // constrained random per-pin trials
    for (int it = 0; it < 150; it++) begin
      int k, mode;
      bit a, b, pol, e;
      logic [31:0] bk;
      k = $urandom_range(NP - 1, 0);
      mode = $urandom_range(4, 0);
      bk = 32'd1 << k;
      pol = (mode == 0 || mode == 2) ? 1'b1 : (mode == 4 ? 1'($urandom_range(1, 0)) : 1'b0);
      a = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : 1'($urandom_range(1, 0));
      b = 1'($urandom_range(1, 0));
      wr(A_EN, 32'h0);
      wr(A_EDGE, mode >= 2 ? bk : 32'h0);
      wr(A_POL, pol ? bk : 32'h0);
      wr(A_BOTH, mode == 4 ? bk : 32'h0);
      pinIn = NP'($urandom());
      pinIn[k] = a;
      waitCyc(4);
      wr(A_CLR, 32'hFFFF_FFFF);
      rd(A_STAT, r0, r1); check("R4 R5 random idle", r0 & bk, 32'h0);
      wr(A_EN, bk);
      pinIn[k] = b;
      waitCyc(3);
      e = expHit(mode, a, b);
      rd(A_STAT, r0, r1); check("R4 R5 R6 random status", r0 & bk, e ? bk : 32'h0);
      check("R8 random irq", 32'(irq0), 32'(e));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule